// File: doc/BRIEF.md
# Dual-Channel Bus-Master Register File

This block is the byte-wide register window of a two-channel disk-controller bus-master unit. Software reaches it through a simple synchronous register bus (address, write enable, write data, read data). Each channel owns an 8-byte window. Within a window the two low address bits pick one of four byte registers: a command byte, a mode byte that both windows share, a status byte and a transfer-timing byte.

The shared mode byte combines two kinds of bit. Per-channel interrupt-pending bits follow the channels' level interrupt inputs. Per-channel blocking bits are written by software. One interrupt output is driven from these bits: it is the OR over the channels of "pending and not blocked".

The status byte combines three kinds of bit. Some take the written value directly. Some are cleared by writing a one to them. One is read-only and is loaded from the command byte. The DMA engine sets the error and interrupt bits through pulse inputs, and a pulse wins over a software clear in the same cycle.

Top module: `bm_regfile`

## Requirements
- R1: After reset every readable byte returns 0x00 and `irq_out` is low.
- R2: `bus_addr[3]` selects the channel window and `bus_addr[1:0]` selects the byte: 0 command, 1 mode, 2 status, 3 timing. Bytes 4 to 7 of either window read 0x00, and writes to them change nothing.
- R3: There is one mode byte, and both windows read the same value from it. Bit 4 blocks channel 0 and bit 5 blocks channel 1. A write to the mode byte through either window changes only bits 5:4.
- R4: Mode bit 2 (channel 0) and bit 3 (channel 1) are the pending bits. Each is loaded from its `chan_irq` input on every clock edge, so each shows the input's level one cycle after it was sampled.
- R5: `irq_out` equals (bit2 AND NOT bit4) OR (bit3 AND NOT bit5) of the mode byte. It follows every change of the mode byte with no extra delay.
- R6: A status write sets bits 6:5 to the written value and keeps bit 0. A written 1 clears bit 1 or bit 2, and a written 0 leaves it unchanged. Bits 7, 4 and 3 become 0.
- R7: A pulse on `dma_err_set[c]` sets status bit 1 of channel c, and a pulse on `dma_int_set[c]` sets status bit 2. Either pulse wins over a software clear of the same bit in the same cycle.
- R8: A command write stores the full byte for the addressed channel and copies bit 0 of the written byte into status bit 0 of that channel.
- R9: Each channel has its own timing byte. It is fully writable, reads back the last value written, and a write to it leaves the other channel's timing byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address within the 16-byte window |
| bus_we | input | 1 | Write strobe, active high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| chan_irq | input | 2 | Level interrupt from each channel |
| dma_err_set | input | 2 | Pulse per channel: set status error bit |
| dma_int_set | input | 2 | Pulse per channel: set status interrupt bit |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
A wrong pending or blocking bit shows up at once on `irq_out`, and also on the mode byte read through either window. This makes a stale or unmasked channel visible in the cycle after the mode byte is written or the interrupt input changes. A corrupted status bit shows up on the next read of that channel's status byte. The sweeps therefore read back after every single write. Wrong channel decoding shows up as data written through one window appearing in the other window, so every write is followed by reads of both windows.

// File: rtl/bm_pkg.sv
package bm_pkg;
   localparam int unsigned BYTE_W   = 8;
   localparam logic [1:0]  SEL_CMD  = 2'd0;
   localparam logic [1:0]  SEL_MODE = 2'd1;
   localparam logic [1:0]  SEL_STAT = 2'd2;
   localparam logic [1:0]  SEL_TIM  = 2'd3;
   // status bit roles
   localparam int unsigned ST_ACT   = 0;
   localparam int unsigned ST_ERR   = 1;
   localparam int unsigned ST_INT   = 2;
   localparam logic [7:0]  ST_DIRECT = 8'h60;
   localparam logic [7:0]  ST_W1C    = 8'h06;
   localparam logic [7:0]  ST_RO     = 8'h01;
   // mode byte layout
   localparam int unsigned MODE_PEND_LSB = 2;
   localparam int unsigned MODE_BLK_LSB  = 4;
endpackage

// File: rtl/bm_chan_regs.sv
module bm_chan_regs
   import bm_pkg::*;
#(
   parameter int unsigned DW = BYTE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [1:0]    sel,
   input  logic [DW-1:0] wdata,
   input  logic          err_set,
   input  logic          int_set,
   output logic [DW-1:0] cmd_q,
   output logic [DW-1:0] stat_q,
   output logic [DW-1:0] tim_q
);
   logic [DW-1:0] cmd_d, stat_d, tim_d;

   initial assert (DW == 8) else $error("bm_chan_regs: DW must be 8");

   always_comb begin
      cmd_d  = cmd_q;
      stat_d = stat_q;
      tim_d  = tim_q;
      if (we) begin
         case (sel)
            SEL_CMD: begin
               cmd_d          = wdata;
               stat_d[ST_ACT] = wdata[0];
            end
            SEL_STAT: stat_d = (wdata & ST_DIRECT) | (stat_q & ST_RO)
                             | (stat_q & ~wdata & ST_W1C);
            SEL_TIM:  tim_d  = wdata;
            default:  ;
         endcase
      end
      if (err_set) stat_d[ST_ERR] = 1'b1;
      if (int_set) stat_d[ST_INT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         stat_q <= '0;
         tim_q  <= '0;
      end else begin
         cmd_q  <= cmd_d;
         stat_q <= stat_d;
         tim_q  <= tim_d;
      end
   end

   // R9
   tim_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_TIM) |=> tim_q == $past(wdata));
   // R6
   w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_STAT && !err_set && !int_set)
      |=> stat_q[2:1] == ($past(stat_q[2:1]) & ~$past(wdata[2:1])));
   // R7
   hw_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_set |=> stat_q[ST_INT]);
   // R8
   act_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_CMD) |=> stat_q[ST_ACT] == $past(wdata[0]));
endmodule

// File: rtl/bm_mode_reg.sv
module bm_mode_reg
   import bm_pkg::*;
#(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned DW     = BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DW-1:0]     wdata,
   input  logic [NUM_CH-1:0] chan_irq,
   output logic [DW-1:0]     mode_q,
   output logic              irq_out
);
   logic [NUM_CH-1:0] pend_q, blk_q, live;

   initial assert (MODE_BLK_LSB + NUM_CH <= DW)
      else $error("bm_mode_reg: channel bits do not fit");

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         blk_q  <= '0;
      end else begin
         pend_q <= chan_irq;
         if (we) blk_q <= wdata[MODE_BLK_LSB +: NUM_CH];
      end
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_live
         assign live[c] = pend_q[c] & ~blk_q[c];
      end
   endgenerate

   always_comb begin
      mode_q = '0;
      mode_q[MODE_PEND_LSB +: NUM_CH] = pend_q;
      mode_q[MODE_BLK_LSB  +: NUM_CH] = blk_q;
   end

   assign irq_out = |live;

   // R3
   blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(mode_q[MODE_BLK_LSB +: NUM_CH]));
   // R4
   pend_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> mode_q[MODE_PEND_LSB +: NUM_CH] == $past(chan_irq));
   // R5
   all_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&mode_q[MODE_BLK_LSB +: NUM_CH]) |-> !irq_out);
endmodule

// File: rtl/bm_regfile.sv
module bm_regfile
   import bm_pkg::*;
#(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned DW     = BYTE_W,
   localparam int unsigned AW    = $clog2(NUM_CH) + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     bus_addr,
   input  logic              bus_we,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [NUM_CH-1:0] chan_irq,
   input  logic [NUM_CH-1:0] dma_err_set,
   input  logic [NUM_CH-1:0] dma_int_set,
   output logic              irq_out
);
   localparam int unsigned CW = AW - 3;

   logic [CW-1:0] ch_sel;
   logic [1:0]    byte_sel;
   logic          in_regs;
   logic          mode_we;
   logic [DW-1:0] mode_q;
   logic [DW-1:0] cmd_q  [NUM_CH];
   logic [DW-1:0] stat_q [NUM_CH];
   logic [DW-1:0] tim_q  [NUM_CH];

   initial assert (NUM_CH == 2) else $error("bm_regfile: two channels only");

   assign ch_sel   = bus_addr[AW-1:3];
   assign byte_sel = bus_addr[1:0];
   assign in_regs  = ~bus_addr[2];
   assign mode_we  = bus_we & in_regs & (byte_sel == SEL_MODE);

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic ch_we;
         assign ch_we = bus_we & in_regs & (ch_sel == CW'(c));
         bm_chan_regs #(.DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (ch_we),
            .sel     (byte_sel),
            .wdata   (bus_wdata),
            .err_set (dma_err_set[c]),
            .int_set (dma_int_set[c]),
            .cmd_q   (cmd_q[c]),
            .stat_q  (stat_q[c]),
            .tim_q   (tim_q[c])
         );
      end
   endgenerate

   bm_mode_reg #(.NUM_CH(NUM_CH), .DW(DW)) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (mode_we),
      .wdata    (bus_wdata),
      .chan_irq (chan_irq),
      .mode_q   (mode_q),
      .irq_out  (irq_out)
   );

   always_comb begin
      bus_rdata = '0;
      if (in_regs) begin
         case (byte_sel)
            SEL_CMD:  bus_rdata = cmd_q[ch_sel];
            SEL_MODE: bus_rdata = mode_q;
            SEL_STAT: bus_rdata = stat_q[ch_sel];
            default:  bus_rdata = tim_q[ch_sel];
         endcase
      end
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !irq_out);
   // R3
   mode_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[1:0] == 2'b00 && mode_q[DW-1:6] == '0);
endmodule

// File: tb/bm_regfile_test.sv
module bm_regfile_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [1:0] chan_irq = '0;
   logic [1:0] dma_err_set = '0;
   logic [1:0] dma_int_set = '0;
   logic       irq_out;

   int tests = 0;
   int failed = 0;

   logic [7:0] m_cmd [2];
   logic [7:0] m_st  [2];
   logic [7:0] m_tim [2];
   logic [1:0] m_blk, m_pend;

   always #(CLK_PERIOD/2) clk = ~clk;

   bm_regfile uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_irq(chan_irq),
      .dma_err_set(dma_err_set), .dma_int_set(dma_int_set), .irq_out(irq_out)
   );

   function automatic logic [7:0] exp_read(input logic [3:0] a);
      int c = a[3];
      if (a[2]) return 8'h00;
      case (a[1:0])
         2'd0: return m_cmd[c];
         2'd1: return {2'b00, m_blk, m_pend, 2'b00};
         2'd2: return m_st[c];
         default: return m_tim[c];
      endcase
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd_chk(input logic [3:0] a, input string tag);
      @(negedge clk);
      bus_addr = a;
      bus_we   = 1'b0;
      #1;
      chk(tag, bus_rdata, exp_read(a));
   endtask

   task automatic irq_chk(input string tag);
      @(negedge clk);
      #1;
      chk(tag, {7'd0, irq_out}, {7'd0, |(m_pend & ~m_blk)});
   endtask

   task automatic model_sets(input logic [1:0] es, input logic [1:0] is);
      for (int c = 0; c < 2; c++) begin
         if (es[c]) m_st[c][1] = 1'b1;
         if (is[c]) m_st[c][2] = 1'b1;
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d,
                     input logic [1:0] es, input logic [1:0] is);
      int c = a[3];
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      dma_err_set = es; dma_int_set = is;
      @(posedge clk);
      #1;
      bus_we = 1'b0; dma_err_set = '0; dma_int_set = '0;
      m_pend = chan_irq;
      if (!a[2]) begin
         case (a[1:0])
            2'd0: begin m_cmd[c] = d; m_st[c][0] = d[0]; end
            2'd1: m_blk = d[5:4];
            2'd2: m_st[c] = (d & 8'h60) | (m_st[c] & 8'h01) | (m_st[c] & ~d & 8'h06);
            default: m_tim[c] = d;
         endcase
      end
      model_sets(es, is);
   endtask

   task automatic tick(input logic [1:0] es, input logic [1:0] is);
      @(negedge clk);
      dma_err_set = es; dma_int_set = is;
      @(posedge clk);
      #1;
      dma_err_set = '0; dma_int_set = '0;
      m_pend = chan_irq;
      model_sets(es, is);
   endtask

   task automatic set_irq(input logic [1:0] v);
      @(negedge clk);
      chan_irq = v;
      @(posedge clk);
      #1;
      m_pend = v;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

   initial begin
      for (int c = 0; c < 2; c++) begin
         m_cmd[c] = '0; m_st[c] = '0; m_tim[c] = '0;
      end
      m_blk = '0; m_pend = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state of every byte and the interrupt line
      for (int a = 0; a < 16; a++) rd_chk(4'(a), "R1 reset read");
      irq_chk("R1 reset irq_out");

      // R8: command sweep, with readback of command and status in both windows
      for (int c = 0; c < 2; c++)
         for (int v = 0; v < 256; v++) begin
            wr(4'(c*8), 8'(v), 2'b00, 2'b00);
            rd_chk(4'(c*8), "R8 command readback");
            rd_chk(4'(c*8+2), "R8 status bit0 copy");
            rd_chk(4'((1-c)*8), "R2 other window command");
         end

      // R6: status sweep from a state with both W1C bits set
      for (int c = 0; c < 2; c++)
         for (int v = 0; v < 256; v++) begin
            tick(2'b11, 2'b11);
            rd_chk(4'(c*8+2), "R7 hw set before write");
            wr(4'(c*8+2), 8'(v), 2'b00, 2'b00);
            rd_chk(4'(c*8+2), "R6 status write");
         end

      // R7: hardware set wins over a same-cycle software clear
      tick(2'b11, 2'b11);
      wr(4'h2, 8'h06, 2'b00, 2'b01);
      rd_chk(4'h2, "R7 int set vs clear");
      wr(4'hA, 8'h06, 2'b10, 2'b00);
      rd_chk(4'hA, "R7 err set vs clear");
      rd_chk(4'h2, "R7 other channel untouched");

      // R9: timing sweep with isolation check
      for (int v = 0; v < 256; v++) begin
         wr(4'h3, 8'(v), 2'b00, 2'b00);
         wr(4'hB, 8'(255 - v), 2'b00, 2'b00);
         rd_chk(4'h3, "R9 timing ch0");
         rd_chk(4'hB, "R9 timing ch1");
      end

      // R3 / R4 / R5: mode sweep under every interrupt input pattern
      for (int i = 0; i < 4; i++) begin
         set_irq(2'(i));
         for (int v = 0; v < 256; v++) begin
            wr(v[0] ? 4'h9 : 4'h1, 8'(v), 2'b00, 2'b00);
            rd_chk(4'h1, "R3 mode via ch0 window");
            rd_chk(4'h9, "R3 mode via ch1 window");
            irq_chk("R5 irq_out after mode write");
         end
      end

      // R4 / R5: pending follows the inputs with no write
      wr(4'h1, 8'h00, 2'b00, 2'b00);
      for (int i = 0; i < 4; i++) begin
         set_irq(2'(i));
         rd_chk(4'h1, "R4 pending follows input");
         irq_chk("R5 irq_out follows input");
      end
      wr(4'h1, 8'h10, 2'b00, 2'b00);
      set_irq(2'b01);
      irq_chk("R5 ch0 blocked");
      set_irq(2'b10);
      irq_chk("R5 ch1 live while ch0 blocked");

      // R2: writes to bytes 4..7 are ignored
      for (int a = 4; a < 8; a++) begin
         wr(4'(a), 8'hFF, 2'b00, 2'b00);
         wr(4'(a+8), 8'hFF, 2'b00, 2'b00);
      end
      for (int a = 0; a < 16; a++) rd_chk(4'(a), "R2 unused bytes ignored");
      irq_chk("R2 irq unchanged");

      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end
endmodule